// File: doc/BRIEF.md
# Distributed Shared-Bus Ownership Tracker

Each processor node that shares an external bus carries one copy of this block. No central arbiter exists. Every copy drives a single active-low request line and samples the whole wired set of request lines. From those lines it works out, on its own, which node owns the bus. All copies apply the same rule on the same clock edge, so their views of the owner never differ.

A 3-bit identity input sets the node's role. Identities 1 to 6 make it one of up to six bus nodes. Identity 0 makes it a lone processor that never arbitrates. Identity 7 is reserved: the node behaves as a lone processor and raises an error flag.

The block reports two things: the identity of the current owner, and a flag that says this node is the owner. The owner flag is gated by a separate enable. The node that wants the bus pulls its line low at the start of a cycle. The owner is updated at the next rising edge from the lines sampled during that cycle.

Top module: `busarb_node`

## Requirements
- R1: An identity of 1 to 6 selects multi-node mode. An identity of 0 selects lone mode. An identity of 7 selects lone-mode behaviour.
- R2: In multi-node mode, bit k of `req_drive_n` belongs to the node with identity k+1. The node pulls only its own bit low, and only while `want_bus` is high. All other bits stay high.
- R3: In lone mode or with the reserved identity, every bit of `req_drive_n` stays high, whatever `want_bus` is.
- R4: After reset the owner is identity 1.
- R5: While the owner's request line (bit owner-1 of `req_lines_n`) is low, the owner does not change.
- R6: When the owner's line is high and at least one line is low, the lowest-numbered low line becomes the owner at the next rising edge.
- R7: When all request lines are high, the owner does not change.
- R8: `is_master` is high only when `bm_en` is high. It is then high in multi-node mode when the owner equals `node_id`, and always high in lone mode.
- R9: `id_err` is high exactly when `node_id` is 7.
- R10: Outside multi-node mode, `master_id` reports `node_id`. In multi-node mode it reports the tracked owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bus cycles run from one rising edge to the next |
| rst | input | 1 | Synchronous active-high reset |
| node_id | input | 3 | Identity of this node |
| want_bus | input | 1 | Local request to own the bus |
| bm_en | input | 1 | Enable for the owner flag |
| req_lines_n | input | 6 | Sampled wired request lines, active low; bit k is identity k+1 |
| req_drive_n | output | 6 | Open-drain style drive of this node's request line, active low |
| master_id | output | 3 | Identity of the current bus owner |
| is_master | output | 1 | This node owns the bus (gated by `bm_en`) |
| id_err | output | 1 | Reserved identity applied |

## Verification
The assertions check several rules on every cycle:
- at most one drive bit is ever low, and all are high outside multi-node mode;
- the owner holds while its line is low, and stays put when all lines are idle;
- the owner flag falls with the enable;
- the error flag tracks identity 7.

Some behaviour only the bench's scenarios can show:
- the fixed-priority choice among several requesters;
- the hand-over after a release;
- the exact bit a given identity drives;
- the reported identity in lone mode.

The bench models the other nodes by wiring their lines together with this node's drive.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

    localparam int NODES_DEF = 6;
    localparam int IDW_DEF   = 3;

    typedef enum logic [1:0] {
        MODE_SOLO  = 2'd0,
        MODE_MULTI = 2'd1,
        MODE_BAD   = 2'd2
    } node_mode_e;

    typedef struct packed {
        node_mode_e mode;
        logic       err;
    } id_info_t;

endpackage

// File: rtl/busarb_id_decode.sv
module busarb_id_decode
    import busarb_pkg::*;
#(
    parameter int N = NODES_DEF,
    parameter int W = IDW_DEF
) (
    input  logic [W-1:0] node_id,
    output id_info_t     info
);
    localparam logic [W-1:0] ID_SOLO = '0;
    localparam logic [W-1:0] ID_MAX  = W'(N);

    always_comb begin
        if (node_id == ID_SOLO) begin
            info.mode = MODE_SOLO;
            info.err  = 1'b0;
        end else if (node_id <= ID_MAX) begin
            info.mode = MODE_MULTI;
            info.err  = 1'b0;
        end else begin
            info.mode = MODE_BAD;
            info.err  = 1'b1;
        end
    end
endmodule

// File: rtl/busarb_req_drive.sv
module busarb_req_drive #(
    parameter int N = 6,
    parameter int W = 3
) (
    input  logic         active,
    input  logic         want_bus,
    input  logic [W-1:0] node_id,
    output logic [N-1:0] drive_n
);
    for (genvar g = 0; g < N; g++) begin : g_line
        localparam logic [W-1:0] LINE_ID = W'(g + 1);
        assign drive_n[g] = !(active && want_bus && (node_id == LINE_ID));
    end
endmodule

// File: rtl/busarb_track.sv
module busarb_track #(
    parameter int N = 6,
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         active,
    input  logic [N-1:0] lines_n,
    output logic [W-1:0] owner_q
);
    localparam logic [W-1:0] OWNER_RST = W'(1);

    logic [N-1:0] req;
    logic         owner_holds;
    logic         found;
    logic [W-1:0] owner_nxt;

    assign req = ~lines_n;

    always_comb begin
        owner_holds = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (owner_q == W'(k + 1)) owner_holds = req[k];
        end
        owner_nxt = owner_q;
        found     = 1'b0;
        if (!owner_holds) begin
            for (int k = 0; k < N; k++) begin
                if (req[k] && !found) begin
                    owner_nxt = W'(k + 1);
                    found     = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         owner_q <= OWNER_RST;
        else if (active) owner_q <= owner_nxt;
    end
endmodule

// File: rtl/busarb_node.sv
module busarb_node
    import busarb_pkg::*;
#(
    parameter int N = NODES_DEF,
    parameter int W = IDW_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] node_id,
    input  logic         want_bus,
    input  logic         bm_en,
    input  logic [N-1:0] req_lines_n,
    output logic [N-1:0] req_drive_n,
    output logic [W-1:0] master_id,
    output logic         is_master,
    output logic         id_err
);
    id_info_t     info;
    logic         multi;
    logic [W-1:0] owner_q;

    busarb_id_decode #(.N(N), .W(W)) u_dec (
        .node_id (node_id),
        .info    (info)
    );

    assign multi  = (info.mode == MODE_MULTI);
    assign id_err = info.err;

    busarb_req_drive #(.N(N), .W(W)) u_drv (
        .active   (multi),
        .want_bus (want_bus),
        .node_id  (node_id),
        .drive_n  (req_drive_n)
    );

    busarb_track #(.N(N), .W(W)) u_trk (
        .clk     (clk),
        .rst     (rst),
        .active  (multi),
        .lines_n (req_lines_n),
        .owner_q (owner_q)
    );

    assign master_id = multi ? owner_q : node_id;
    assign is_master = bm_en && (multi ? (owner_q == node_id) : 1'b1);
endmodule

// File: rtl/busarb_chk.sv
module busarb_chk #(
    parameter int N = 6,
    parameter int W = 3
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] node_id,
    input logic         bm_en,
    input logic [N-1:0] req_lines_n,
    input logic [N-1:0] req_drive_n,
    input logic [W-1:0] master_id,
    input logic         is_master,
    input logic         id_err
);
    logic multi;
    logic own_line_n;
    logic all_idle;

    assign multi    = (node_id != '0) && (node_id <= W'(N));
    assign all_idle = &req_lines_n;

    always_comb begin
        own_line_n = 1'b1;
        for (int k = 0; k < N; k++) begin
            if (master_id == W'(k + 1)) own_line_n = req_lines_n[k];
        end
    end

    a_r2_single_drive: assert property (@(posedge clk) disable iff (rst)
        $countones(~req_drive_n) <= 1);

    a_r3_quiet_solo: assert property (@(posedge clk) disable iff (rst)
        !multi |-> (&req_drive_n));

    a_r4_reset_owner: assert property (@(posedge clk) disable iff (rst)
        (multi && $past(rst)) |-> (master_id == W'(1)));

    a_r5_owner_holds: assert property (@(posedge clk) disable iff (rst)
        (multi && !own_line_n) |=> (!$stable(node_id) || $stable(master_id)));

    a_r7_idle_keeps: assert property (@(posedge clk) disable iff (rst)
        (multi && all_idle) |=> (!$stable(node_id) || $stable(master_id)));

    a_r8_enable_gate: assert property (@(posedge clk) disable iff (rst)
        !bm_en |-> !is_master);

    a_r8_solo_owner: assert property (@(posedge clk) disable iff (rst)
        (bm_en && !multi) |-> is_master);

    a_r9_err_flag: assert property (@(posedge clk) disable iff (rst)
        id_err == (&node_id));
endmodule

bind busarb_node busarb_chk #(.N(N), .W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .node_id     (node_id),
    .bm_en       (bm_en),
    .req_lines_n (req_lines_n),
    .req_drive_n (req_drive_n),
    .master_id   (master_id),
    .is_master   (is_master),
    .id_err      (id_err)
);

// File: tb/test_busarb_node.sv
module test_busarb_node;
    localparam int CLK_PERIOD = 10;
    localparam int N = 6;
    localparam int W = 3;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] node_id;
    logic         want_bus;
    logic         bm_en;
    logic [N-1:0] others_n;
    logic [N-1:0] req_lines_n;
    logic [N-1:0] req_drive_n;
    logic [W-1:0] master_id;
    logic         is_master;
    logic         id_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // wired-AND of the other nodes and this node
    assign req_lines_n = others_n & req_drive_n;

    busarb_node #(.N(N), .W(W)) i_busarb_node (
        .clk         (clk),
        .rst         (rst),
        .node_id     (node_id),
        .want_bus    (want_bus),
        .bm_en       (bm_en),
        .req_lines_n (req_lines_n),
        .req_drive_n (req_drive_n),
        .master_id   (master_id),
        .is_master   (is_master),
        .id_err      (id_err)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic restart(logic [W-1:0] id);
        @(negedge clk);
        node_id  = id;
        want_bus = 1'b0;
        bm_en    = 1'b1;
        others_n = '1;
        rst      = 1'b1;
        step(2);
        rst = 1'b0;
    endtask

    task automatic t_reset_state;
        restart(3'd3);
        check("R4 owner after reset", master_id, 3'd1);
        check("R8 not owner after reset", is_master, 1'b0);
        check("R2 idle drive", req_drive_n, 6'h3F);
        check("R9 no error", id_err, 1'b0);
    endtask

    task automatic t_own_line;
        restart(3'd3);
        want_bus = 1'b1;
        #1;
        check("R2 own line bit2", req_drive_n, 6'b111011);
        step(1);
        check("R6 sole requester wins", master_id, 3'd3);
        check("R8 owner flag", is_master, 1'b1);
        node_id = 3'd6;
        #1;
        check("R2 id6 drives bit5", req_drive_n, 6'b011111);
    endtask

    task automatic t_hold;
        restart(3'd3);
        others_n = 6'b111110;
        want_bus = 1'b1;
        step(3);
        check("R5 owner 1 holds", master_id, 3'd1);
        check("R5 not owner while held", is_master, 1'b0);
        others_n = '1;
        step(1);
        check("R6 handover after release", master_id, 3'd3);
    endtask

    task automatic t_priority;
        restart(3'd4);
        others_n = 6'b101101;
        want_bus = 1'b1;
        step(1);
        check("R6 lowest of 2,4,5", master_id, 3'd2);
        step(2);
        check("R5 owner 2 holds", master_id, 3'd2);
        others_n = 6'b101111;
        step(1);
        check("R6 lowest of 4,5", master_id, 3'd4);
        check("R8 owner flag id4", is_master, 1'b1);
        // idle bus keeps owner
        others_n = '1;
        want_bus = 1'b0;
        step(3);
        check("R7 idle keeps owner", master_id, 3'd4);
        bm_en = 1'b0;
        #1;
        check("R8 enable low gates flag", is_master, 1'b0);
        bm_en = 1'b1;
        #1;
        check("R8 enable high restores flag", is_master, 1'b1);
    endtask

    task automatic t_solo;
        restart(3'd0);
        others_n = 6'b111101;
        want_bus = 1'b1;
        #1;
        check("R3 solo drives nothing", req_drive_n, 6'h3F);
        check("R10 solo reports own id", master_id, 3'd0);
        check("R1 solo is owner", is_master, 1'b1);
        step(2);
        check("R10 solo id after edges", master_id, 3'd0);
        check("R9 solo no error", id_err, 1'b0);
        bm_en = 1'b0;
        #1;
        check("R8 solo gated", is_master, 1'b0);
    endtask

    task automatic t_reserved;
        restart(3'd7);
        want_bus = 1'b1;
        step(1);
        check("R9 reserved error", id_err, 1'b1);
        check("R3 reserved drives nothing", req_drive_n, 6'h3F);
        check("R1 reserved acts solo", is_master, 1'b1);
        check("R10 reserved reports id", master_id, 3'd7);
    endtask

    initial begin
        rst      = 1'b1;
        node_id  = '0;
        want_bus = 1'b0;
        bm_en    = 1'b1;
        others_n = '1;
        t_reset_state();
        t_own_line();
        t_hold();
        t_priority();
        t_solo();
        t_reserved();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule